// File: doc/BRIEF.md
# Burst-of-Two Synchronous SRAM Core

This block models a common-I/O synchronous SRAM in which every access moves two data beats over one shared data bus. It runs at beat rate: each clock edge is one beat, and every second beat is a command slot in which a read strobe, a write strobe and an address are sampled. Inside, each array word is twice the bus width. A write collects its two beats in a de-multiplexer and stores them as one wide word. A read fetches one wide word and sends its two halves out one beat at a time.

The low address bit picks which half leads the transfer, so the requested word goes first. A variant chosen by parameter fixes the order and ignores that bit. Writes are late: data follows the command by a slot, and the array is updated a slot after that. A forwarding path keeps reads coherent with every write still in flight, including its byte masks. The data bus is split into an input, an output and an output-enable flag, which suits an FPGA fabric.

Top module: `b2_sram`

## Requirements
- R1: Beat 0 after reset is a command slot, and slots then fall on every second beat. `cmd_slot` is high exactly in slot beats.
- R2: Strobes and address presented in a beat that is not a slot are ignored. They cause no read output, no array change and no error.
- R3: A write command in slot beat t takes its data from `dq_i` in beats t+2 (first beat) and t+3 (second beat). The two beats are stored together as one array word at index `addr[ADDR_W-1:1]`.
- R4: A read command in slot beat t drives its data on `dq_o` in beats t+2 and t+3. `dq_oe` is high in exactly those beats and low otherwise.
- R5: With CRIT_FIRST=1, the first beat of an access maps to word half `addr[0]` and the second beat to the other half. Half 0 is bits [DQ_W-1:0] and half 1 is bits [2*DQ_W-1:DQ_W]. A word written with `addr[0]`=0 and read back with `addr[0]`=1 therefore comes out with its beats swapped.
- R6: With CRIT_FIRST=0, `addr[0]` has no effect. Every access moves half 0 first, then half 1.
- R7: Each beat carries its own byte enables. `be[i]`=1 writes bits [i*BYTE_W +: BYTE_W] of that beat. `be[i]`=0 leaves the stored byte unchanged.
- R8: A read returns the data of every write issued in an earlier slot, with its masks applied. This holds even when that write's data is still arriving in the slot just before the read, or has not yet reached the array.
- R9: If both strobes are high in a slot, the read is performed and the write is dropped. `cmd_err` then rises in the next beat and stays high until reset.
- R10: While reset is high and in beat 0, `dq_oe` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one rising edge per data beat |
| rst | input | 1 | Synchronous active-high reset |
| cmd_slot | output | 1 | High in beats where a command is sampled |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word index in the upper bits, beat order in bit 0 |
| be | input | DQ_W/BYTE_W | Per-byte write enables for the current data beat |
| dq_i | input | DQ_W | Write data beat |
| dq_o | output | DQ_W | Read data beat |
| dq_oe | output | 1 | Output enable for `dq_o` |
| cmd_err | output | 1 | Sticky flag for a slot with both strobes high |

## Verification
Some rules are checked by assertions on every cycle. These are that slots alternate with idle beats, that the output enable comes in pairs starting in a slot beat, that a slot without a read is followed two beats later by a disabled bus, and that the error flag rises after a double strobe and then stays high. The returned data itself is left to the bench scenarios. Those scenarios cover half ordering in both variants, byte merging, forwarding from a write whose second beat is still on the bus, and forwarding from a write not yet committed to the array. All of these are checked against a behavioural reference array.

// File: rtl/b2_pkg.sv
package b2_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } b2_cmd_e;
endpackage

// File: rtl/b2_slot_ctrl.sv
module b2_slot_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int CRIT_FIRST = 1,
  localparam int IDX_W     = ADDR_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic             slot,
  output logic             rd_go,
  output logic             wr_go,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_a0,
  output logic             err
);
  import b2_pkg::*;

  localparam logic ORDER_BY_ADDR = (CRIT_FIRST != 0);

  logic    ph;
  b2_cmd_e cmd_k;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign slot = ~ph;

  always_comb begin
    cmd_k = CMD_NONE;
    if (slot && rd_en)      cmd_k = CMD_RD;
    else if (slot && wr_en) cmd_k = CMD_WR;
  end

  assign rd_go   = (cmd_k == CMD_RD);
  assign wr_go   = (cmd_k == CMD_WR);
  assign cmd_idx = addr[ADDR_W-1:1];
  assign cmd_a0  = addr[0] & ORDER_BY_ADDR;

  always_ff @(posedge clk) begin
    if (rst)                         err <= 1'b0;
    else if (slot && rd_en && wr_en) err <= 1'b1;
  end
endmodule

// File: rtl/b2_wr_pipe.sv
module b2_wr_pipe #(
  parameter int DQ_W    = 36,
  parameter int BYTE_W  = 9,
  parameter int IDX_W   = 10,
  localparam int NB     = DQ_W / BYTE_W,
  localparam int W2     = 2 * DQ_W,
  localparam int NL     = 2 * NB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot,
  input  logic             wr_go,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_a0,
  input  logic [DQ_W-1:0]  dq_i,
  input  logic [NB-1:0]    be,
  output logic             inc_v,
  output logic [IDX_W-1:0] inc_idx,
  output logic [W2-1:0]    inc_d,
  output logic [NL-1:0]    inc_we,
  output logic             pw_v,
  output logic             pw_new,
  output logic [IDX_W-1:0] pw_idx,
  output logic [W2-1:0]    pw_d,
  output logic [NL-1:0]    pw_we
);
  logic             wc_v, wc_a0;
  logic [IDX_W-1:0] wc_idx;
  logic             dmx_v, dmx_a0;
  logic [IDX_W-1:0] dmx_idx;
  logic [DQ_W-1:0]  dmx_d0;
  logic [NB-1:0]    dmx_m0;

  // command stage and first-beat capture, both on slot edges
  always_ff @(posedge clk) begin
    if (rst) begin
      wc_v  <= 1'b0;
      dmx_v <= 1'b0;
    end else if (slot) begin
      wc_v  <= wr_go;
      dmx_v <= wc_v;
    end
  end

  always_ff @(posedge clk) begin
    if (slot) begin
      wc_idx  <= cmd_idx;
      wc_a0   <= cmd_a0;
      dmx_idx <= wc_idx;
      dmx_a0  <= wc_a0;
      dmx_d0  <= dq_i;
      dmx_m0  <= be;
    end
  end

  // assembled wide word: first beat from the register, second beat live
  always_comb begin
    for (int h = 0; h < 2; h++) begin
      if (h == int'(dmx_a0)) begin
        inc_d[h*DQ_W +: DQ_W] = dmx_d0;
        inc_we[h*NB +: NB]    = dmx_m0;
      end else begin
        inc_d[h*DQ_W +: DQ_W] = dq_i;
        inc_we[h*NB +: NB]    = be;
      end
    end
  end

  assign inc_v   = dmx_v;
  assign inc_idx = dmx_idx;

  // pending late write, loaded on the second data beat
  always_ff @(posedge clk) begin
    if (rst) begin
      pw_v   <= 1'b0;
      pw_new <= 1'b0;
    end else if (!slot) begin
      pw_v   <= dmx_v;
      pw_new <= dmx_v;
    end else begin
      pw_new <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!slot && dmx_v) begin
      pw_idx <= dmx_idx;
      pw_d   <= inc_d;
      pw_we  <= inc_we;
    end
  end
endmodule

// File: rtl/b2_mem.sv
module b2_mem #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 72,
  parameter int BYTE_W = 9,
  localparam int NL    = WORD_W / BYTE_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wd,
  input  logic [NL-1:0]     wbe,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rq
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < NL; l++) begin
        if (wbe[l]) mem[widx][l*BYTE_W +: BYTE_W] <= wd[l*BYTE_W +: BYTE_W];
      end
    end
    if (re) rq <= mem[ridx];
  end
endmodule

// File: rtl/b2_rd_path.sv
module b2_rd_path #(
  parameter int DQ_W   = 36,
  parameter int BYTE_W = 9,
  parameter int IDX_W  = 10,
  localparam int NB    = DQ_W / BYTE_W,
  localparam int W2    = 2 * DQ_W,
  localparam int NL    = 2 * NB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot,
  input  logic             rd_go,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_a0,
  input  logic [W2-1:0]    rq,
  input  logic             pw_v,
  input  logic [IDX_W-1:0] pw_idx,
  input  logic [W2-1:0]    pw_d,
  input  logic [NL-1:0]    pw_we,
  input  logic             inc_v,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [W2-1:0]    inc_d,
  input  logic [NL-1:0]    inc_we,
  output logic [DQ_W-1:0]  dq_o,
  output logic             dq_oe
);
  logic             rc_v, rc_a0, sec;
  logic [IDX_W-1:0] rc_idx;
  logic [W2-1:0]    merged;
  logic [DQ_W-1:0]  hold, first_b, second_b;
  logic             pw_hit, inc_hit;

  always_ff @(posedge clk) begin
    if (rst)       rc_v <= 1'b0;
    else if (slot) rc_v <= rd_go;
  end

  always_ff @(posedge clk) begin
    if (slot) begin
      rc_idx <= cmd_idx;
      rc_a0  <= cmd_a0;
    end
  end

  assign pw_hit  = pw_v  && (pw_idx  == rc_idx);
  assign inc_hit = inc_v && (inc_idx == rc_idx);

  // newest write wins per byte lane, then the pending write, then the array
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign merged[g*BYTE_W +: BYTE_W] =
      (inc_hit && inc_we[g]) ? inc_d[g*BYTE_W +: BYTE_W] :
      (pw_hit  && pw_we[g])  ? pw_d[g*BYTE_W +: BYTE_W]  :
                               rq[g*BYTE_W +: BYTE_W];
  end

  assign first_b  = rc_a0 ? merged[W2-1:DQ_W] : merged[DQ_W-1:0];
  assign second_b = rc_a0 ? merged[DQ_W-1:0]  : merged[W2-1:DQ_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe <= 1'b0;
      dq_o  <= '0;
      sec   <= 1'b0;
      hold  <= '0;
    end else if (!slot && rc_v) begin
      dq_o  <= first_b;
      hold  <= second_b;
      dq_oe <= 1'b1;
      sec   <= 1'b1;
    end else if (sec) begin
      dq_o  <= hold;
      dq_oe <= 1'b1;
      sec   <= 1'b0;
    end else begin
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/b2_sram.sv
module b2_sram #(
  parameter int ADDR_W     = 11,
  parameter int DQ_W       = 36,
  parameter int BYTE_W     = 9,
  parameter int CRIT_FIRST = 1,
  localparam int NB        = DQ_W / BYTE_W,
  localparam int IDX_W     = ADDR_W - 1,
  localparam int W2        = 2 * DQ_W,
  localparam int NL        = 2 * NB
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cmd_slot,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     be,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe,
  output logic              cmd_err
);
  logic             slot, rd_go, wr_go, cmd_a0;
  logic [IDX_W-1:0] cmd_idx;
  logic             inc_v, pw_v, pw_new;
  logic [IDX_W-1:0] inc_idx, pw_idx;
  logic [W2-1:0]    inc_d, pw_d, rq;
  logic [NL-1:0]    inc_we, pw_we;

  b2_slot_ctrl #(.ADDR_W(ADDR_W), .CRIT_FIRST(CRIT_FIRST)) u_ctrl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .slot(slot), .rd_go(rd_go), .wr_go(wr_go), .cmd_idx(cmd_idx),
    .cmd_a0(cmd_a0), .err(cmd_err)
  );

  b2_wr_pipe #(.DQ_W(DQ_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst(rst), .slot(slot), .wr_go(wr_go), .cmd_idx(cmd_idx),
    .cmd_a0(cmd_a0), .dq_i(dq_i), .be(be),
    .inc_v(inc_v), .inc_idx(inc_idx), .inc_d(inc_d), .inc_we(inc_we),
    .pw_v(pw_v), .pw_new(pw_new), .pw_idx(pw_idx), .pw_d(pw_d), .pw_we(pw_we)
  );

  b2_mem #(.IDX_W(IDX_W), .WORD_W(W2), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .we(slot && pw_new), .widx(pw_idx), .wd(pw_d), .wbe(pw_we),
    .re(rd_go), .ridx(cmd_idx), .rq(rq)
  );

  b2_rd_path #(.DQ_W(DQ_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .slot(slot), .rd_go(rd_go), .cmd_idx(cmd_idx),
    .cmd_a0(cmd_a0), .rq(rq),
    .pw_v(pw_v), .pw_idx(pw_idx), .pw_d(pw_d), .pw_we(pw_we),
    .inc_v(inc_v), .inc_idx(inc_idx), .inc_d(inc_d), .inc_we(inc_we),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  assign cmd_slot = slot;
endmodule

// File: rtl/b2_sram_chk.sv
module b2_sram_chk (
  input logic clk,
  input logic rst,
  input logic cmd_slot,
  input logic rd_en,
  input logic wr_en,
  input logic dq_oe,
  input logic cmd_err
);
  // R1
  slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_slot |=> !cmd_slot);
  // R1
  slot_back_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_slot |=> cmd_slot);
  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> cmd_slot);
  // R4
  oe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |=> dq_oe);
  // R2
  no_rd_no_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_slot && !rd_en) |=> ##1 !dq_oe);
  // R4
  rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_slot && rd_en) |=> ##1 dq_oe);
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_slot && rd_en && wr_en) |=> cmd_err);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);
endmodule

bind b2_sram b2_sram_chk u_chk (
  .clk(clk), .rst(rst), .cmd_slot(cmd_slot), .rd_en(rd_en),
  .wr_en(wr_en), .dq_oe(dq_oe), .cmd_err(cmd_err)
);

// File: tb/b2_sram_bench.sv
module b2_sram_bench;
  localparam int ADDR_W = 4;
  localparam int DQ_W   = 36;
  localparam int BYTE_W = 9;
  localparam int NB     = DQ_W / BYTE_W;
  localparam int NW     = 1 << (ADDR_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NB-1:0] be = '0;
  logic [DQ_W-1:0] dq_i = '0;
  logic slot1, slot2, oe1, oe2, err1, err2;
  logic [DQ_W-1:0] q1, q2;

  always #5 clk = ~clk;

  b2_sram #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .BYTE_W(BYTE_W), .CRIT_FIRST(1)) u_b2_sram (
    .clk(clk), .rst(rst), .cmd_slot(slot1), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .be(be), .dq_i(dq_i), .dq_o(q1), .dq_oe(oe1), .cmd_err(err1));

  b2_sram #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .BYTE_W(BYTE_W), .CRIT_FIRST(0)) u_b2_sram_fix (
    .clk(clk), .rst(rst), .cmd_slot(slot2), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .be(be), .dq_i(dq_i), .dq_o(q2), .dq_oe(oe2), .cmd_err(err2));

  int checks = 0, errors = 0, t = 0;
  bit done = 1'b0;
  logic [DQ_W-1:0] m1 [NW][2];
  logic [DQ_W-1:0] m2 [NW][2];
  bit              ev [4];
  logic [DQ_W-1:0] e1 [4];
  logic [DQ_W-1:0] e2 [4];
  bit model_err = 1'b0, err_pend = 1'b0;
  bit dw_v = 1'b0, dw_a0 = 1'b0;
  int dw_idx = 0;
  logic [DQ_W-1:0] dw_d0, dw_d1;
  logic [NB-1:0] dw_m0, dw_m1;

  task automatic chk(input bit ok, input string req, input logic [DQ_W-1:0] act, input logic [DQ_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s beat %0d actual=%h expected=%h", req, t, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] rnd();
    logic [63:0] v = {$urandom(), $urandom()};
    return v[DQ_W-1:0];
  endfunction

  task automatic apply_beat(input int idx, input bit a0, input int bn, input logic [DQ_W-1:0] d, input logic [NB-1:0] m);
    int h1 = bn ^ int'(a0);
    for (int i = 0; i < NB; i++) begin
      if (m[i]) begin
        m1[idx][h1][i*BYTE_W +: BYTE_W] = d[i*BYTE_W +: BYTE_W];
        m2[idx][bn][i*BYTE_W +: BYTE_W] = d[i*BYTE_W +: BYTE_W];
      end
    end
  endtask

  task automatic check_beat();
    int s = t % 4;
    chk(slot1 == ((t % 2) == 0), "R1 slot", {35'd0, slot1}, {35'd0, (t % 2) == 0});
    chk(err1 == model_err && err2 == model_err, "R9 err", {35'd0, err1}, {35'd0, model_err});
    chk(oe1 == ev[s], "R4 R2 oe", {35'd0, oe1}, {35'd0, ev[s]});
    chk(oe2 == ev[s], "R4 R2 oe fixed", {35'd0, oe2}, {35'd0, ev[s]});
    if (ev[s]) begin
      chk(q1 == e1[s], "R3 R5 R7 R8 data", q1, e1[s]);
      chk(q2 == e2[s], "R6 fixed-order data", q2, e2[s]);
    end
    ev[s] = 1'b0;
  endtask

  task automatic do_slot(input bit r, input bit w, input logic [ADDR_W-1:0] a,
                         input logic [DQ_W-1:0] d0, input logic [DQ_W-1:0] d1,
                         input logic [NB-1:0] mk0, input logic [NB-1:0] mk1);
    int idx = int'(a[ADDR_W-1:1]);
    // slot beat
    check_beat();
    rd_en = r; wr_en = w; addr = a;
    if (r && w) err_pend = 1'b1;
    if (dw_v) begin
      dq_i = dw_d0; be = dw_m0;
      apply_beat(dw_idx, dw_a0, 0, dw_d0, dw_m0);
    end else begin
      dq_i = rnd(); be = NB'($urandom());
    end
    @(negedge clk); t++;
    // idle beat: stray strobes must be ignored (R2)
    if (err_pend) begin model_err = 1'b1; err_pend = 1'b0; end
    check_beat();
    rd_en = $urandom_range(0, 1); wr_en = $urandom_range(0, 1); addr = ADDR_W'($urandom());
    if (dw_v) begin
      dq_i = dw_d1; be = dw_m1;
      apply_beat(dw_idx, dw_a0, 1, dw_d1, dw_m1);
    end else begin
      dq_i = rnd(); be = NB'($urandom());
    end
    if (r) begin
      ev[(t + 1) % 4] = 1'b1; ev[(t + 2) % 4] = 1'b1;
      e1[(t + 1) % 4] = m1[idx][a[0]];  e1[(t + 2) % 4] = m1[idx][!a[0]];
      e2[(t + 1) % 4] = m2[idx][0];     e2[(t + 2) % 4] = m2[idx][1];
    end
    dw_v = w && !r; dw_idx = idx; dw_a0 = a[0];
    dw_d0 = d0; dw_d1 = d1; dw_m0 = mk0; dw_m1 = mk1;
    @(negedge clk); t++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ev[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(oe1 == 1'b0 && oe2 == 1'b0, "R10 oe in reset", {35'd0, oe1}, '0);
    chk(err1 == 1'b0 && err2 == 1'b0, "R10 err in reset", {35'd0, err1}, '0);
    rst = 1'b0;
    // fill the array with full masks, alternating the order bit
    for (int i = 0; i < NW; i++)
      do_slot(1'b0, 1'b1, ADDR_W'(i * 2 + (i % 2)), rnd(), rnd(), '1, '1);
    // R8: read right after a write whose second beat is still arriving
    do_slot(1'b0, 1'b1, 4'd6, 36'hA_AAAA_0001, 36'hB_BBBB_0002, '1, '1);
    do_slot(1'b1, 1'b0, 4'd6, '0, '0, '0, '0);
    // R5: same word read with the other half first
    do_slot(1'b1, 1'b0, 4'd7, '0, '0, '0, '0);
    // R7 R8: masked write, one idle slot, then read from the pending write
    do_slot(1'b0, 1'b1, 4'd7, 36'h1_2345_6789, 36'hF_EDCB_A987, 4'b0101, 4'b1010);
    do_slot(1'b0, 1'b0, 4'd0, '0, '0, '0, '0);
    do_slot(1'b1, 1'b0, 4'd6, '0, '0, '0, '0);
    do_slot(1'b0, 1'b0, 4'd0, '0, '0, '0, '0);
    do_slot(1'b1, 1'b0, 4'd7, '0, '0, '0, '0);
    // random traffic before any double strobe
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 9);
      do_slot(k < 4, k >= 4 && k < 8, ADDR_W'($urandom()), rnd(), rnd(),
              NB'($urandom()), NB'($urandom()));
    end
    // R9: both strobes; the read happens, the write is dropped
    do_slot(1'b1, 1'b1, 4'd3, 36'h0_DEAD_BEEF, 36'h0_FACE_FEED, '1, '1);
    do_slot(1'b0, 1'b0, 4'd0, '0, '0, '0, '0);
    do_slot(1'b1, 1'b0, 4'd3, '0, '0, '0, '0);
    for (int n = 0; n < 500; n++) begin
      int k = $urandom_range(0, 9);
      do_slot(k < 4, k >= 4 && k < 9, ADDR_W'($urandom()), rnd(), rnd(),
              NB'($urandom()), NB'($urandom()));
    end
    for (int n = 0; n < 3; n++) do_slot(1'b0, 1'b0, '0, '0, '0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired at beat %0d actual=running expected=finished", t);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule